// File: doc/BRIEF.md
# Downstream Bus Activity Monitor

This block observes the two open-drain lines of a downstream two-wire serial bus, clock and data. It decides at every cycle whether the bus is idle or carrying a transaction. A transaction opens when the data line falls while the clock line is high. It closes when the data line rises while the clock line is high. Both raw lines pass through a synchronizer of configurable depth before any edge is judged.

The surrounding selector switches ownership of the downstream bus between upstream controllers. It reports each switch to this block with a one-cycle strobe. If a switch lands in the middle of a transaction while automatic recovery is turned off, the block latches an interrupt request. That request tells the new owner that it must run a bus recovery of its own. The request can be suppressed with a mask input. Once latched, it stays up until a clear strobe acknowledges it.

Top module: `bus_activity_monitor`

## Requirements
- R1: After reset, `busBusy` and `irqReq` are both 0.
- R2: A START sets `busBusy` to 1. A START is a high-to-low change of the synchronized data line while the synchronized clock line is 1 in both of the two samples. `busBusy` rises at the (SYNC_STAGES+1)-th rising clock edge after the raw data line changes, and not before.
- R3: A STOP clears `busBusy` to 0. A STOP is a low-to-high change of the synchronized data line while the synchronized clock line is 1 in both of the two samples.
- R4: Data-line changes made while the clock line is 0 leave `busBusy` unchanged. Clock and data falling together in the same sample is not a START.
- R5: A `switchStrobe` pulse sets `irqReq` on the next rising edge. This happens when, in that cycle, `busBusy` is 1, `recoveryEn` is 0 and `maskIrq` is 0.
- R6: A `switchStrobe` pulse while `busBusy` is 0 does not set `irqReq`.
- R7: A `switchStrobe` pulse while `recoveryEn` is 1 does not set `irqReq`.
- R8: A `switchStrobe` pulse while `maskIrq` is 1 does not set `irqReq`.
- R9: `irqReq` holds until a cycle with `irqClear` at 1, and then drops on the next edge. When a new request and a clear come in the same cycle, the request wins.
- R10: A repeated START while `busBusy` is 1 keeps `busBusy` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclRaw | input | 1 | Raw downstream clock line |
| sdaRaw | input | 1 | Raw downstream data line |
| switchStrobe | input | 1 | One-cycle pulse when bus ownership changes |
| recoveryEn | input | 1 | Automatic recovery enabled; disables the flagging |
| maskIrq | input | 1 | Suppresses new interrupt requests |
| irqClear | input | 1 | Acknowledge strobe that clears the request |
| busBusy | output | 1 | 1 while a transaction is open |
| irqReq | output | 1 | Latched request for an external bus recovery |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that the START latency follows the parameter: the bench checks that `busBusy` is still low after three edges and high after the fourth. With the deeper chain, every bus action must also settle longer before it is judged. The random mix of STARTs, STOPs, data bits, switches and clears therefore exercises switch strobes on both sides of the busy window. It also covers repeated STARTs and set-over-clear collisions.

// File: rtl/bam_pkg.sv
package bam_pkg;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic startSeen;
    logic stopSeen;
  } lineEvt_t;

endpackage

// File: rtl/bam_sync.sv
module bam_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/bam_datapath.sv
module bam_datapath
  import bam_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRaw,
  input  logic     sdaRaw,
  output lineEvt_t evt
);
  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] nowLines;
  logic [NUM_LINES-1:0] prevLines;

  assign rawLines[LINE_SCL] = sclRaw;
  assign rawLines[LINE_SDA] = sdaRaw;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    bam_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .d    (rawLines[g]),
      .q    (nowLines[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= nowLines;
  end

  logic clockHeld;
  assign clockHeld = prevLines[LINE_SCL] & nowLines[LINE_SCL];

  always_comb begin
    evt.startSeen = clockHeld & prevLines[LINE_SDA] & ~nowLines[LINE_SDA];
    evt.stopSeen  = clockHeld & ~prevLines[LINE_SDA] & nowLines[LINE_SDA];
  end
endmodule

// File: rtl/bam_control.sv
module bam_control
  import bam_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  lineEvt_t evt,
  input  logic     switchStrobe,
  input  logic     recoveryEn,
  input  logic     maskIrq,
  input  logic     irqClear,
  output logic     busBusy,
  output logic     irqReq
);
  logic busyQ;
  logic reqQ;
  logic raiseReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busyQ <= 1'b0;
    else if (evt.startSeen) busyQ <= 1'b1;
    else if (evt.stopSeen)  busyQ <= 1'b0;
  end

  assign raiseReq = switchStrobe & busyQ & ~recoveryEn & ~maskIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= raiseReq | (reqQ & ~irqClear);
  end

  assign busBusy = busyQ;
  assign irqReq  = reqQ;
endmodule

// File: rtl/bus_activity_monitor.sv
module bus_activity_monitor
  import bam_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  input  logic switchStrobe,
  input  logic recoveryEn,
  input  logic maskIrq,
  input  logic irqClear,
  output logic busBusy,
  output logic irqReq
);
  lineEvt_t evt;

  bam_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .sclRaw (sclRaw),
    .sdaRaw (sdaRaw),
    .evt    (evt)
  );

  bam_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (evt),
    .switchStrobe (switchStrobe),
    .recoveryEn   (recoveryEn),
    .maskIrq      (maskIrq),
    .irqClear     (irqClear),
    .busBusy      (busBusy),
    .irqReq       (irqReq)
  );
endmodule

// File: rtl/bam_checker.sv
module bam_checker (
  input logic clk,
  input logic rstN,
  input logic switchStrobe,
  input logic recoveryEn,
  input logic maskIrq,
  input logic irqClear,
  input logic busBusy,
  input logic irqReq
);
  assert_switch_sets_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (switchStrobe && busBusy && !recoveryEn && !maskIrq) |=> irqReq);

  assert_idle_switch_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(switchStrobe && busBusy));

  assert_recovery_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> !$past(recoveryEn));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> !$past(maskIrq));

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqClear) |=> irqReq);

  assert_irq_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !switchStrobe) |=> !irqReq);
endmodule

bind bus_activity_monitor bam_checker u_bam_checker (
  .clk          (clk),
  .rstN         (rstN),
  .switchStrobe (switchStrobe),
  .recoveryEn   (recoveryEn),
  .maskIrq      (maskIrq),
  .irqClear     (irqClear),
  .busBusy      (busBusy),
  .irqReq       (irqReq)
);

// File: tb/bus_activity_monitor_bench.sv
module bus_activity_monitor_bench;
  localparam int STAGES = 3;
  localparam int SETTLE = STAGES + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRaw = 1'b1;
  logic sdaRaw = 1'b1;
  logic switchStrobe = 1'b0;
  logic recoveryEn = 1'b0;
  logic maskIrq = 1'b0;
  logic irqClear = 1'b0;
  logic busBusy;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  logic expBusy = 1'b0;
  logic expIrq = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_activity_monitor #(.SYNC_STAGES(STAGES)) u_bus_activity_monitor (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .switchStrobe(switchStrobe), .recoveryEn(recoveryEn), .maskIrq(maskIrq),
    .irqClear(irqClear), .busBusy(busBusy), .irqReq(irqReq)
  );

  function automatic logic nextIrq(logic old, logic sw, logic busy,
                                   logic rec, logic msk, logic clr);
    return (sw && busy && !rec && !msk) || (old && !clr);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic scl, logic sda);
    @(negedge clk);
    sclRaw = scl;
    sdaRaw = sda;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic doStart(string tag);
    drive(1'b0, sdaRaw);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    expBusy = 1'b1;
    check(tag, busBusy, expBusy);
  endtask

  task automatic doStop();
    drive(1'b0, sdaRaw);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    expBusy = 1'b0;
    check("R3 stop clears busy", busBusy, expBusy);
  endtask

  task automatic doBit(logic b);
    drive(1'b0, sdaRaw);
    drive(1'b0, b);
    drive(1'b1, b);
    drive(1'b0, b);
    check("R4 data bit keeps busy", busBusy, expBusy);
  endtask

  task automatic pulse(logic sw, logic rec, logic msk, logic clr, string tag);
    @(negedge clk);
    switchStrobe = sw;
    recoveryEn = rec;
    maskIrq = msk;
    irqClear = clr;
    expIrq = nextIrq(expIrq, sw, expBusy, rec, msk, clr);
    @(negedge clk);
    switchStrobe = 1'b0;
    recoveryEn = 1'b0;
    maskIrq = 1'b0;
    irqClear = 1'b0;
    check(tag, irqReq, expIrq);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busBusy, 1'b0);
    check("R1 irq after reset", irqReq, 1'b0);
    rstN = 1'b1;
    repeat (SETTLE) @(negedge clk);

    // R6: switch while idle
    pulse(1'b1, 1'b0, 1'b0, 1'b0, "R6 idle switch");

    // R4: clock and data fall together is not a START
    drive(1'b0, 1'b0);
    check("R4 joint fall no start", busBusy, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);

    // R2: exact latency of START
    @(negedge clk);
    sdaRaw = 1'b0;
    repeat (STAGES) @(negedge clk);
    check("R2 busy not yet", busBusy, 1'b0);
    @(negedge clk);
    check("R2 busy at latency", busBusy, 1'b1);
    expBusy = 1'b1;
    repeat (SETTLE) @(negedge clk);

    doBit(1'b1);
    doBit(1'b0);
    pulse(1'b1, 1'b1, 1'b0, 1'b0, "R7 recovery blocks");
    pulse(1'b1, 1'b0, 1'b1, 1'b0, "R8 mask blocks");
    pulse(1'b1, 1'b0, 1'b0, 1'b0, "R5 busy switch sets irq");
    repeat (5) @(negedge clk);
    check("R9 irq holds", irqReq, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 1'b1, "R9 set wins over clear");
    pulse(1'b0, 1'b0, 1'b0, 1'b1, "R9 clear drops irq");
    doStart("R10 repeated start keeps busy");
    doStop();
    pulse(1'b1, 1'b0, 1'b0, 1'b0, "R6 switch after stop");

    for (int i = 0; i < 250; i++) begin
      int unsigned op;
      logic a;
      logic b;
      op = $urandom % 6;
      a = 1'($urandom % 4 == 0);
      b = 1'($urandom % 4 == 0);
      case (op)
        0: doStart(expBusy ? "R10 random restart" : "R2 random start");
        1: doStop();
        2: doBit(1'($urandom));
        3: pulse(1'b1, a, b, 1'b0, "R5 R7 R8 random switch");
        4: pulse(1'b0, 1'b0, 1'b0, 1'b1, "R9 random clear");
        default: pulse(1'b1, a, b, 1'b1, "R9 random switch with clear");
      endcase
    end
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule